// File: doc/BRIEF.md
# Radio Transmit/Receive Power-Up Sequencer

This block walks a transceiver from one of its low-power idle modes into an active transmit or receive mode. A request bit for each direction starts a fixed series of steps: bring up the regulators, start the crystal oscillator and wait for it, turn on the synthesizer, optionally calibrate the VCO, let the synthesizer settle, and then either ramp the power amplifier or switch on the receive chain. Each step raises an enable strobe that drives the matching analog or modem block. The sequencer does not model any of those blocks.

The idle mode in force when a request arrives decides where the walk begins. Work that the idle mode has already done is not repeated. The three wait periods are counted in clock cycles by one shared down-counter, and the length of each period is a parameter. VCO calibration is handed to an external calibrator through a start pulse and a done input. A configuration bit can bypass that step. Clearing the request bit that started the walk returns the block to idle at any point.

Top module: `radio_seq_top`

## Requirements
- R1: While reset is high and in the first cycle after it, `seq_state` is 0 (IDLE) and all six enable outputs and `vco_cal_start` are low.
- R2: In IDLE the enables follow `idle_mode`. Code 0 (STANDBY) drives all enables low. Code 1 (READY) drives `reg_en` and `xo_en` high. Code 2 (TUNE) drives `reg_en`, `xo_en` and `pll_en` high. Code 3 behaves as STANDBY.
- R3: A request from STANDBY passes through the states in this order: 1 (REG_UP, one cycle), 2 (XO_WAIT), 3 (PLL_UP, one cycle), 4 (VCO_CAL), 5 (PLL_SETTLE), then the tail. The first state appears on the clock edge that samples the request.
- R4: XO_WAIT lasts exactly XO_CYC cycles, PLL_SETTLE lasts SETTLE_CYC cycles and PA_RAMP lasts RAMP_CYC cycles.
- R5: On entering VCO_CAL, `vco_cal_start` is high for exactly one cycle. The state holds until `vco_cal_done` is sampled high and then moves to PLL_SETTLE. With `skip_vco` set to 1, PLL_UP goes straight to PLL_SETTLE.
- R6: From READY the walk starts at PLL_UP. From TUNE it starts directly at the first tail state.
- R7: The transmit tail is 6 (PA_RAMP), followed by 7 (TX_RUN), which holds while the request stays set.
- R8: The receive tail is 8 (RX_FRONT, one cycle), followed by 9 (RX_RUN), which holds while the request stays set.
- R9: If both request bits are set in IDLE, transmit is chosen. Once a walk has begun, the request bit for the other direction has no effect on the state.
- R10: If the request bit of the running direction is low in any non-IDLE state, the next state is IDLE and the enables return to the R2 set for `idle_mode`.
- R11: Outside IDLE, `reg_en` is high in every state. `xo_en` is high from XO_WAIT onward. `pll_en` is high from PLL_UP onward. `pa_en` is high in PA_RAMP and TX_RUN. `rxfe_en` is high in RX_FRONT and RX_RUN. `modem_rx_en` is high only in RX_RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_on | input | 1 | Transmit request level |
| rx_on | input | 1 | Receive request level |
| skip_vco | input | 1 | 1 bypasses VCO calibration |
| idle_mode | input | 2 | Idle mode: 0 STANDBY, 1 READY, 2 TUNE |
| vco_cal_done | input | 1 | Calibrator finished |
| reg_en | output | 1 | Regulator enable |
| xo_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | Synthesizer enable |
| vco_cal_start | output | 1 | One-cycle calibration start |
| pa_en | output | 1 | Power amplifier enable |
| rxfe_en | output | 1 | LNA, mixer and ADC enable |
| modem_rx_en | output | 1 | Modem receive path enable |
| seq_state | output | 4 | Current state code |

## Verification
The assertions assume that the calibrator raises `vco_cal_done` only in answer to a start pulse, and that `idle_mode` is changed only while the block sits in IDLE. The abort property also assumes that the request bits are levels and not pulses. The bench changes `idle_mode` and `skip_vco` only before it raises a request. It pulses `vco_cal_done` once, a few cycles after it sees the start strobe. It clears a request bit only when it means to test an abort.

// File: rtl/radio_seq_pkg.sv
package radio_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE       = 4'd0,
    ST_REG_UP     = 4'd1,
    ST_XO_WAIT    = 4'd2,
    ST_PLL_UP     = 4'd3,
    ST_VCO_CAL    = 4'd4,
    ST_PLL_SETTLE = 4'd5,
    ST_PA_RAMP    = 4'd6,
    ST_TX_RUN     = 4'd7,
    ST_RX_FRONT   = 4'd8,
    ST_RX_RUN     = 4'd9
  } seq_state_e;

  localparam logic [1:0] MODE_STANDBY = 2'd0;
  localparam logic [1:0] MODE_READY   = 2'd1;
  localparam logic [1:0] MODE_TUNE    = 2'd2;

  typedef struct packed {
    logic reg_en;
    logic xo_en;
    logic pll_en;
    logic pa_en;
    logic rxfe_en;
    logic modem_rx_en;
  } en_vec_t;

  function automatic en_vec_t enables_for(seq_state_e s, logic [1:0] mode);
    en_vec_t e;
    e = '0;
    if (s == ST_IDLE) begin
      e.reg_en = (mode == MODE_READY) || (mode == MODE_TUNE);
      e.xo_en  = e.reg_en;
      e.pll_en = (mode == MODE_TUNE);
    end else begin
      e.reg_en      = 1'b1;
      e.xo_en       = (s != ST_REG_UP);
      e.pll_en      = (s != ST_REG_UP) && (s != ST_XO_WAIT);
      e.pa_en       = (s == ST_PA_RAMP) || (s == ST_TX_RUN);
      e.rxfe_en     = (s == ST_RX_FRONT) || (s == ST_RX_RUN);
      e.modem_rx_en = (s == ST_RX_RUN);
    end
    return e;
  endfunction

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          expired
);

  logic [TW-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)              count_q <= '0;
    else if (load)        count_q <= load_val;
    else if (count_q != 0) count_q <= count_q - 1'b1;
  end

  assign expired = (count_q == '0);

  // R4: without a load the counter only moves downward
  assert_timer_down_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && count_q != '0) |=> (count_q < $past(count_q)));

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import radio_seq_pkg::*;
#(
  parameter int XO_CYC     = 600,
  parameter int SETTLE_CYC = 40,
  parameter int RAMP_CYC   = 10,
  parameter int TW         = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_on,
  input  logic          rx_on,
  input  logic          skip_vco,
  input  logic [1:0]    idle_mode,
  input  logic          vco_cal_done,
  input  logic          tmr_expired,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output en_vec_t       en_q,
  output logic          cal_start_q,
  output seq_state_e    state_q
);

  logic       dir_tx_q, dir_tx_n;
  seq_state_e state_n;
  logic [1:0] mode_norm;
  logic       active;

  assign mode_norm = (idle_mode == 2'd3) ? MODE_STANDBY : idle_mode;
  assign active    = dir_tx_q ? tx_on : rx_on;

  always_comb begin
    state_n  = state_q;
    dir_tx_n = dir_tx_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (state_q == ST_IDLE) begin
      if (tx_on || rx_on) begin
        dir_tx_n = tx_on;
        unique case (mode_norm)
          MODE_READY: state_n = ST_PLL_UP;
          MODE_TUNE: begin
            if (tx_on) begin
              state_n  = ST_PA_RAMP;
              tmr_load = 1'b1;
              tmr_val  = TW'(RAMP_CYC - 1);
            end else begin
              state_n = ST_RX_FRONT;
            end
          end
          default: state_n = ST_REG_UP;
        endcase
      end
    end else if (!active) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_REG_UP: begin
          state_n  = ST_XO_WAIT;
          tmr_load = 1'b1;
          tmr_val  = TW'(XO_CYC - 1);
        end
        ST_XO_WAIT: if (tmr_expired) state_n = ST_PLL_UP;
        ST_PLL_UP: begin
          if (skip_vco) begin
            state_n  = ST_PLL_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
          end else begin
            state_n = ST_VCO_CAL;
          end
        end
        ST_VCO_CAL: begin
          if (vco_cal_done) begin
            state_n  = ST_PLL_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = TW'(SETTLE_CYC - 1);
          end
        end
        ST_PLL_SETTLE: begin
          if (tmr_expired) begin
            if (dir_tx_q) begin
              state_n  = ST_PA_RAMP;
              tmr_load = 1'b1;
              tmr_val  = TW'(RAMP_CYC - 1);
            end else begin
              state_n = ST_RX_FRONT;
            end
          end
        end
        ST_PA_RAMP:  if (tmr_expired) state_n = ST_TX_RUN;
        ST_RX_FRONT: state_n = ST_RX_RUN;
        default:     state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      dir_tx_q    <= 1'b0;
      en_q        <= '0;
      cal_start_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      dir_tx_q    <= dir_tx_n;
      en_q        <= enables_for(state_n, mode_norm);
      cal_start_q <= (state_n == ST_VCO_CAL) && (state_q != ST_VCO_CAL);
    end
  end

  // R5: calibration start is a single-cycle strobe
  assert_cal_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    cal_start_q |=> !cal_start_q);

  // R5: without done the calibration step does not move forward
  assert_cal_wait_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_VCO_CAL && !vco_cal_done) |=>
      (state_q == ST_VCO_CAL || state_q == ST_IDLE));

  // R10: no request bit at all forces a return to idle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE && !tx_on && !rx_on) |=> (state_q == ST_IDLE));

  // R11: amplifier and receive chain are never on together
  assert_tail_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(en_q.pa_en && en_q.rxfe_en));

  // R8: modem path only after the front end was already up
  assert_rx_order_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(en_q.modem_rx_en) |-> $past(en_q.rxfe_en));

  // R3: synthesizer rises during a walk only once the crystal is running
  assert_pll_after_xo_R3: assert property (@(posedge clk) disable iff (rst)
    ($rose(en_q.pll_en) && state_q != ST_IDLE) |-> $past(en_q.xo_en));

endmodule

// File: rtl/radio_seq_top.sv
module radio_seq_top
  import radio_seq_pkg::*;
#(
  parameter int XO_CYC     = 600,
  parameter int SETTLE_CYC = 40,
  parameter int RAMP_CYC   = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tx_on,
  input  logic       rx_on,
  input  logic       skip_vco,
  input  logic [1:0] idle_mode,
  input  logic       vco_cal_done,
  output logic       reg_en,
  output logic       xo_en,
  output logic       pll_en,
  output logic       vco_cal_start,
  output logic       pa_en,
  output logic       rxfe_en,
  output logic       modem_rx_en,
  output logic [3:0] seq_state
);

  localparam int MAX_A = (XO_CYC > SETTLE_CYC) ? XO_CYC : SETTLE_CYC;
  localparam int MAX_C = (MAX_A > RAMP_CYC) ? MAX_A : RAMP_CYC;
  localparam int TW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  logic          tmr_load, tmr_expired;
  logic [TW-1:0] tmr_val;
  en_vec_t       en;
  seq_state_e    st;

  seq_wait_timer #(.TW(TW)) timer_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .expired(tmr_expired)
  );

  seq_fsm #(
    .XO_CYC(XO_CYC), .SETTLE_CYC(SETTLE_CYC), .RAMP_CYC(RAMP_CYC), .TW(TW)
  ) fsm_i (
    .clk(clk), .rst(rst), .tx_on(tx_on), .rx_on(rx_on),
    .skip_vco(skip_vco), .idle_mode(idle_mode),
    .vco_cal_done(vco_cal_done), .tmr_expired(tmr_expired),
    .tmr_load(tmr_load), .tmr_val(tmr_val), .en_q(en),
    .cal_start_q(vco_cal_start), .state_q(st)
  );

  assign reg_en      = en.reg_en;
  assign xo_en       = en.xo_en;
  assign pll_en      = en.pll_en;
  assign pa_en       = en.pa_en;
  assign rxfe_en     = en.rxfe_en;
  assign modem_rx_en = en.modem_rx_en;
  assign seq_state   = st;

endmodule

// File: tb/radio_seq_top_tb_top.sv
module radio_seq_top_tb_top;

  localparam int XO = 3;
  localparam int ST = 2;
  localparam int RP = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_on = 1'b0, rx_on = 1'b0, skip_vco = 1'b0, vco_cal_done = 1'b0;
  logic [1:0] idle_mode = 2'd0;
  logic reg_en, xo_en, pll_en, vco_cal_start, pa_en, rxfe_en, modem_rx_en;
  logic [3:0] seq_state;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  radio_seq_top #(.XO_CYC(XO), .SETTLE_CYC(ST), .RAMP_CYC(RP)) dut_i (
    .clk(clk), .rst(rst), .tx_on(tx_on), .rx_on(rx_on), .skip_vco(skip_vco),
    .idle_mode(idle_mode), .vco_cal_done(vco_cal_done), .reg_en(reg_en),
    .xo_en(xo_en), .pll_en(pll_en), .vco_cal_start(vco_cal_start),
    .pa_en(pa_en), .rxfe_en(rxfe_en), .modem_rx_en(modem_rx_en),
    .seq_state(seq_state)
  );

  // expected {reg,xo,pll,pa,rxfe,modem} from the R2 / R11 tables
  function automatic logic [5:0] exp_en(int s, int mode);
    if (s == 0) begin
      if (mode == 1) return 6'b110000;
      if (mode == 2) return 6'b111000;
      return 6'b000000;
    end
    if (s == 1) return 6'b100000;
    if (s == 2) return 6'b110000;
    if (s >= 3 && s <= 5) return 6'b111000;
    if (s == 6 || s == 7) return 6'b111100;
    if (s == 8) return 6'b111010;
    return 6'b111011;
  endfunction

  task automatic chk(int s, int mode, string req);
    logic [5:0] got;
    got = {reg_en, xo_en, pll_en, pa_en, rxfe_en, modem_rx_en};
    checks++;
    if (seq_state != 4'(s) || got != exp_en(s, mode)) begin
      errors++;
      $display("FAIL %s state=%0d en=%b expected state=%0d en=%b",
               req, seq_state, got, s, exp_en(s, mode));
    end
  endtask

  task automatic chk_start(logic e, string req);
    checks++;
    if (vco_cal_start !== e) begin
      errors++;
      $display("FAIL %s vco_cal_start=%b expected %b", req, vco_cal_start, e);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic run_walk(bit tx, int mode, bit skip);
    idle_mode = 2'(mode); skip_vco = skip; tx_on = 0; rx_on = 0;
    tick(); tick();
    chk(0, mode, "R2 idle enables");
    if (tx) tx_on = 1; else rx_on = 1;
    tick();
    if (mode == 0 || mode == 3) begin
      chk(1, mode, "R3 REG_UP"); tick();
      for (int i = 0; i < XO; i++) begin chk(2, mode, "R4 XO_WAIT"); tick(); end
    end
    if (mode != 2) begin
      chk(3, mode, "R6 R3 PLL_UP"); tick();
      if (!skip) begin
        chk(4, mode, "R5 VCO_CAL"); chk_start(1'b1, "R5 start");
        tick(); chk(4, mode, "R5 hold"); chk_start(1'b0, "R5 pulse end");
        tick(); chk(4, mode, "R5 wait done");
        vco_cal_done = 1; tick(); vco_cal_done = 0;
      end
      for (int i = 0; i < ST; i++) begin chk(5, mode, "R4 PLL_SETTLE"); tick(); end
    end
    if (tx) begin
      for (int i = 0; i < RP; i++) begin chk(6, mode, "R7 R4 PA_RAMP"); tick(); end
      chk(7, mode, "R7 TX_RUN"); tick(); chk(7, mode, "R7 TX_RUN hold");
    end else begin
      chk(8, mode, "R8 RX_FRONT"); tick();
      chk(9, mode, "R8 RX_RUN"); tick(); chk(9, mode, "R8 RX_RUN hold");
    end
    tx_on = 0; rx_on = 0;
    tick();
    chk(0, mode, "R10 back to idle");
  endtask

  initial begin
    repeat (3) tick();
    chk(0, 0, "R1 reset"); chk_start(1'b0, "R1 reset");
    rst = 0;
    tick();
    chk(0, 0, "R1 after reset");
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 2; s++)
          run_walk(d[0], m, s[0]);

    // R9 priority from TUNE
    idle_mode = 2; tick();
    tx_on = 1; rx_on = 1; tick();
    chk(6, 2, "R9 tx priority");
    rx_on = 0; tick(); chk(6, 2, "R9 rx ignored");
    tx_on = 0; tick(); chk(0, 2, "R10 abort");

    // R9 tx ignored during receive walk, then R10 abort with restart
    rx_on = 1; tick(); chk(8, 2, "R9 rx start");
    tx_on = 1; tick(); chk(9, 2, "R9 tx ignored");
    tick(); chk(9, 2, "R9 tx ignored hold");
    rx_on = 0; tick(); chk(0, 2, "R10 rx dropped");
    tick(); chk(6, 2, "R9 restart tx");
    tx_on = 0; tick(); chk(0, 2, "R10 abort");

    // R10 abort from STANDBY during crystal wait
    idle_mode = 0; skip_vco = 0; tick();
    tx_on = 1; tick(); chk(1, 0, "R3 REG_UP");
    tick(); chk(2, 0, "R4 XO_WAIT");
    tx_on = 0; tick(); chk(0, 0, "R10 abort in XO_WAIT");
    tick(); chk(0, 0, "R10 stays idle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule